// File: doc/BRIEF.md
# Multicycle Processor Control Decoder

This block turns the current step of a multicycle 32-bit processor, together with the instruction's 6-bit opcode and two ALU result flags, into the full set of datapath control lines for that cycle. It has no storage. The sequencing state machine lives elsewhere and supplies its 3-bit step code as an input. The decoder answers "what must the datapath do right now" within a single combinational settle time.

Static, per-instruction choices come from the opcode alone: the ALU function, the operand sources, the extension mode and the destination register. Everything that commits architectural state is gated by the step code: register write, data-memory access, instruction-register load and program-counter update. Conditional branches choose between the sequential and the relative program-counter source from the zero or sign flag.

Top module: `cpu_ctrl_decoder`

## Requirements
- R1: `irWrite` is 1 only in the fetch step (step code 000). `imemRead` is 1 in every step.
- R2: `aluSrcShamt` is 1 only for opcode 011000 (shift-left), and only while the step code is 110, 101 or 010. It is 0 in every other case.
- R3: `aluSrcImm` is 1 for opcodes 000010, 010001, 010010, 010011, 100110, 110001 and 110000. It is 0 for every other opcode.
- R4: `extSign` is 1 for opcodes 000010, 100110, 110001, 110000, 110100, 110101 and 110110. It is 0 for every other opcode, including the zero-extended logic immediates 010001, 010010 and 010011.
- R5: `aluOp` uses the codes add 000, subtract 001, shift-left 010, or 011, and 100, unsigned-less 101, signed-less 110 and xor 111. It is chosen by opcode as follows: 000000, 000010, 110000 and 110001 give add; 000001 and all three branches give subtract; 011000 gives shift-left; 010000 and 010001 give and; 010010 gives or; 010011 gives xor; 100110 and 100111 give signed-less; any other opcode gives add.
- R6: `regDst` is 10 (rd) for 000000, 000001, 010000, 011000 and 100111. It is 01 (rt) for 000010, 010001, 010010, 010011, 100110 and 110001. It is 00 (link) for 111010 and for every other opcode.
- R7: `pcSrc` is 11 for 111000 and 111010, and 10 for 111001. It is 01 for 110100 when `aluZero`=1, for 110101 when `aluZero`=0, and for 110110 when `aluSign`=1. Otherwise it is 00.
- R8: `regWrite` is 1 in exactly three cases: step 111 for the ALU opcodes listed in R6 as rd or rt other than 110001; step 100 for 110001; and step 001 for 111010. `wrDataAlu` is 0 only for 111010.
- R9: `wbFromMem` is 1 only for 110001. `dmemRead` is 1 only for 110001 in step 011. `dmemWrite` is 1 only for 110000 in step 011.
- R10: `pcWriteEn` marks the last step of an instruction. It is 1 in step 001 for 111000, 111001 and 111010; in step 101 for the branches; in step 011 for 110000; in step 100 for 110001; and in step 111 for ALU-class and unknown opcodes. Opcode 111111 (halt) never asserts it.
- R11: An opcode outside the listed set behaves as a harmless ALU instruction. It gives add, register operands and `regDst` 00. It never writes a register or memory, and it completes in step 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phase | input | 3 | Current sequencer step code |
| opcode | input | 6 | Instruction opcode field |
| aluZero | input | 1 | ALU result is zero |
| aluSign | input | 1 | ALU result sign bit |
| pcWriteEn | output | 1 | Update the program counter this cycle |
| aluSrcShamt | output | 1 | ALU A takes the shift amount instead of a register |
| aluSrcImm | output | 1 | ALU B takes the extended immediate instead of a register |
| wbFromMem | output | 1 | Write-back value comes from data memory |
| regWrite | output | 1 | Register file write enable |
| wrDataAlu | output | 1 | 1: write result data, 0: write return address |
| imemRead | output | 1 | Instruction memory read |
| dmemRead | output | 1 | Data memory read |
| dmemWrite | output | 1 | Data memory write |
| irWrite | output | 1 | Load the instruction register |
| extSign | output | 1 | 1: sign-extend immediate, 0: zero-extend |
| pcSrc | output | 2 | Next-PC source select |
| regDst | output | 2 | Destination register select |
| aluOp | output | 3 | ALU function code |

## Verification
The checker continuously confirms the phase-gating rules. Instruction-register loads happen only in fetch, and the shift-amount operand appears only in execute steps. Register writes occur only in write-back or in the link step, data-memory strobes appear only in the memory step and never together, and halt never moves the program counter. The per-opcode tables can only be shown by the bench's sweep over every step, opcode and flag combination. These tables cover ALU codes, extension mode, destination select, the flag-dependent branch sources and the completion steps. Directed scenarios add to the sweep for branches, halt, the link instruction and unknown opcodes.

// File: rtl/cpu_ctrl_pkg.sv
package cpu_ctrl_pkg;
  localparam int PHASE_W  = 3;
  localparam int OPC_W    = 6;
  localparam int ALUOP_W  = 3;
  localparam int PCSRC_W  = 2;
  localparam int REGDST_W = 2;

  // sequencer step codes
  localparam logic [PHASE_W-1:0] PH_FETCH   = 3'b000;
  localparam logic [PHASE_W-1:0] PH_DECODE  = 3'b001;
  localparam logic [PHASE_W-1:0] PH_EXE_ARI = 3'b110;
  localparam logic [PHASE_W-1:0] PH_EXE_BRN = 3'b101;
  localparam logic [PHASE_W-1:0] PH_EXE_MEM = 3'b010;
  localparam logic [PHASE_W-1:0] PH_MEMACC  = 3'b011;
  localparam logic [PHASE_W-1:0] PH_WB_ARI  = 3'b111;
  localparam logic [PHASE_W-1:0] PH_WB_LOAD = 3'b100;

  // opcodes
  localparam logic [OPC_W-1:0] OPC_ADD   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_SUB   = 6'b000001;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_AND   = 6'b010000;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'b010001;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'b010010;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'b010011;
  localparam logic [OPC_W-1:0] OPC_SHL   = 6'b011000;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'b100110;
  localparam logic [OPC_W-1:0] OPC_SLT   = 6'b100111;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b110000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b110001;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b110100;
  localparam logic [OPC_W-1:0] OPC_BNE   = 6'b110101;
  localparam logic [OPC_W-1:0] OPC_BLTZ  = 6'b110110;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'b111000;
  localparam logic [OPC_W-1:0] OPC_JREG  = 6'b111001;
  localparam logic [OPC_W-1:0] OPC_JLINK = 6'b111010;
  localparam logic [OPC_W-1:0] OPC_HALT  = 6'b111111;

  // ALU functions
  localparam logic [ALUOP_W-1:0] ALU_ADD = 3'b000;
  localparam logic [ALUOP_W-1:0] ALU_SUB = 3'b001;
  localparam logic [ALUOP_W-1:0] ALU_SHL = 3'b010;
  localparam logic [ALUOP_W-1:0] ALU_OR  = 3'b011;
  localparam logic [ALUOP_W-1:0] ALU_AND = 3'b100;
  localparam logic [ALUOP_W-1:0] ALU_LTU = 3'b101;
  localparam logic [ALUOP_W-1:0] ALU_LTS = 3'b110;
  localparam logic [ALUOP_W-1:0] ALU_XOR = 3'b111;

  // next-PC sources
  localparam logic [PCSRC_W-1:0] PCS_SEQ = 2'b00;
  localparam logic [PCSRC_W-1:0] PCS_REL = 2'b01;
  localparam logic [PCSRC_W-1:0] PCS_REG = 2'b10;
  localparam logic [PCSRC_W-1:0] PCS_ABS = 2'b11;

  // destination register selects
  localparam logic [REGDST_W-1:0] RDST_LINK = 2'b00;
  localparam logic [REGDST_W-1:0] RDST_RT   = 2'b01;
  localparam logic [REGDST_W-1:0] RDST_RD   = 2'b10;

  typedef enum logic [2:0] {
    CLS_ARITH, CLS_NOWRITE, CLS_LOAD, CLS_STORE, CLS_BRANCH, CLS_JUMP, CLS_HALT
  } instrClass_t;

  typedef enum logic [1:0] {BR_EQ, BR_NE, BR_LTZ, BR_NONE} brKind_t;
  typedef enum logic [1:0] {JMP_ABS, JMP_LINK, JMP_REG, JMP_NONE} jmpKind_t;

  typedef struct packed {
    instrClass_t          cls;
    brKind_t              brKind;
    jmpKind_t             jmpKind;
    logic                 isShift;
    logic                 immOperand;
    logic                 signExt;
    logic [ALUOP_W-1:0]   aluOp;
    logic [REGDST_W-1:0]  regDst;
  } instrInfo_t;

  typedef struct packed {
    logic                 pcWriteEn;
    logic                 aluSrcShamt;
    logic                 aluSrcImm;
    logic                 wbFromMem;
    logic                 regWrite;
    logic                 wrDataAlu;
    logic                 imemRead;
    logic                 dmemRead;
    logic                 dmemWrite;
    logic                 irWrite;
    logic                 extSign;
    logic [PCSRC_W-1:0]   pcSrc;
    logic [REGDST_W-1:0]  regDst;
    logic [ALUOP_W-1:0]   aluOp;
  } ctrlStrobes_t;
endpackage

// File: rtl/cpu_op_decode.sv
module cpu_op_decode
  import cpu_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output instrInfo_t       info
);
  always_comb begin
    info = '{cls: CLS_NOWRITE, brKind: BR_NONE, jmpKind: JMP_NONE,
             isShift: 1'b0, immOperand: 1'b0, signExt: 1'b0,
             aluOp: ALU_ADD, regDst: RDST_LINK};
    unique case (opcode)
      OPC_ADD:  begin info.cls = CLS_ARITH; info.regDst = RDST_RD; end
      OPC_SUB:  begin info.cls = CLS_ARITH; info.regDst = RDST_RD; info.aluOp = ALU_SUB; end
      OPC_AND:  begin info.cls = CLS_ARITH; info.regDst = RDST_RD; info.aluOp = ALU_AND; end
      OPC_SLT:  begin info.cls = CLS_ARITH; info.regDst = RDST_RD; info.aluOp = ALU_LTS; end
      OPC_SHL:  begin
        info.cls = CLS_ARITH; info.regDst = RDST_RD; info.aluOp = ALU_SHL; info.isShift = 1'b1;
      end
      OPC_ADDI: begin
        info.cls = CLS_ARITH; info.regDst = RDST_RT; info.immOperand = 1'b1; info.signExt = 1'b1;
      end
      OPC_SLTI: begin
        info.cls = CLS_ARITH; info.regDst = RDST_RT; info.immOperand = 1'b1; info.signExt = 1'b1;
        info.aluOp = ALU_LTS;
      end
      OPC_ANDI: begin
        info.cls = CLS_ARITH; info.regDst = RDST_RT; info.immOperand = 1'b1; info.aluOp = ALU_AND;
      end
      OPC_ORI:  begin
        info.cls = CLS_ARITH; info.regDst = RDST_RT; info.immOperand = 1'b1; info.aluOp = ALU_OR;
      end
      OPC_XORI: begin
        info.cls = CLS_ARITH; info.regDst = RDST_RT; info.immOperand = 1'b1; info.aluOp = ALU_XOR;
      end
      OPC_LOAD: begin
        info.cls = CLS_LOAD; info.regDst = RDST_RT; info.immOperand = 1'b1; info.signExt = 1'b1;
      end
      OPC_STORE: begin
        info.cls = CLS_STORE; info.immOperand = 1'b1; info.signExt = 1'b1;
      end
      OPC_BEQ:  begin info.cls = CLS_BRANCH; info.brKind = BR_EQ;  info.signExt = 1'b1; info.aluOp = ALU_SUB; end
      OPC_BNE:  begin info.cls = CLS_BRANCH; info.brKind = BR_NE;  info.signExt = 1'b1; info.aluOp = ALU_SUB; end
      OPC_BLTZ: begin info.cls = CLS_BRANCH; info.brKind = BR_LTZ; info.signExt = 1'b1; info.aluOp = ALU_SUB; end
      OPC_JMP:   begin info.cls = CLS_JUMP; info.jmpKind = JMP_ABS;  end
      OPC_JLINK: begin info.cls = CLS_JUMP; info.jmpKind = JMP_LINK; end
      OPC_JREG:  begin info.cls = CLS_JUMP; info.jmpKind = JMP_REG;  end
      OPC_HALT:  info.cls = CLS_HALT;
      default:   ;
    endcase
  end
endmodule

// File: rtl/cpu_pc_select.sv
module cpu_pc_select
  import cpu_ctrl_pkg::*;
(
  input  instrInfo_t         info,
  input  logic               aluZero,
  input  logic               aluSign,
  output logic [PCSRC_W-1:0] pcSrc
);
  logic takeBranch;

  always_comb begin
    unique case (info.brKind)
      BR_EQ:   takeBranch = aluZero;
      BR_NE:   takeBranch = !aluZero;
      BR_LTZ:  takeBranch = aluSign;
      default: takeBranch = 1'b0;
    endcase
  end

  always_comb begin
    unique case (info.jmpKind)
      JMP_ABS, JMP_LINK: pcSrc = PCS_ABS;
      JMP_REG:           pcSrc = PCS_REG;
      default:           pcSrc = takeBranch ? PCS_REL : PCS_SEQ;
    endcase
  end
endmodule

// File: rtl/cpu_phase_gate.sv
module cpu_phase_gate
  import cpu_ctrl_pkg::*;
(
  input  logic [PHASE_W-1:0] phase,
  input  instrInfo_t         info,
  input  logic [PCSRC_W-1:0] pcSrc,
  output ctrlStrobes_t       strobes
);
  logic inExecute;
  logic isLink;
  logic lastStep;
  logic writeBack;

  assign inExecute = (phase == PH_EXE_ARI) || (phase == PH_EXE_BRN) || (phase == PH_EXE_MEM);
  assign isLink    = (info.jmpKind == JMP_LINK);

  always_comb begin
    unique case (info.cls)
      CLS_ARITH, CLS_NOWRITE: lastStep = (phase == PH_WB_ARI);
      CLS_LOAD:               lastStep = (phase == PH_WB_LOAD);
      CLS_STORE:              lastStep = (phase == PH_MEMACC);
      CLS_BRANCH:             lastStep = (phase == PH_EXE_BRN);
      CLS_JUMP:               lastStep = (phase == PH_DECODE);
      default:                lastStep = 1'b0;
    endcase
  end

  always_comb begin
    unique case (info.cls)
      CLS_ARITH: writeBack = (phase == PH_WB_ARI);
      CLS_LOAD:  writeBack = (phase == PH_WB_LOAD);
      CLS_JUMP:  writeBack = isLink && (phase == PH_DECODE);
      default:   writeBack = 1'b0;
    endcase
  end

  always_comb begin
    strobes.pcWriteEn   = lastStep;
    strobes.aluSrcShamt = info.isShift && inExecute;
    strobes.aluSrcImm   = info.immOperand;
    strobes.wbFromMem   = (info.cls == CLS_LOAD);
    strobes.regWrite    = writeBack;
    strobes.wrDataAlu   = !isLink;
    strobes.imemRead    = 1'b1;
    strobes.dmemRead    = (info.cls == CLS_LOAD)  && (phase == PH_MEMACC);
    strobes.dmemWrite   = (info.cls == CLS_STORE) && (phase == PH_MEMACC);
    strobes.irWrite     = (phase == PH_FETCH);
    strobes.extSign     = info.signExt;
    strobes.pcSrc       = pcSrc;
    strobes.regDst      = info.regDst;
    strobes.aluOp       = info.aluOp;
  end
endmodule

// File: rtl/cpu_ctrl_decoder.sv
module cpu_ctrl_decoder
  import cpu_ctrl_pkg::*;
(
  input  logic [PHASE_W-1:0]  phase,
  input  logic [OPC_W-1:0]    opcode,
  input  logic                aluZero,
  input  logic                aluSign,
  output logic                pcWriteEn,
  output logic                aluSrcShamt,
  output logic                aluSrcImm,
  output logic                wbFromMem,
  output logic                regWrite,
  output logic                wrDataAlu,
  output logic                imemRead,
  output logic                dmemRead,
  output logic                dmemWrite,
  output logic                irWrite,
  output logic                extSign,
  output logic [PCSRC_W-1:0]  pcSrc,
  output logic [REGDST_W-1:0] regDst,
  output logic [ALUOP_W-1:0]  aluOp
);
  instrInfo_t         info;
  logic [PCSRC_W-1:0] nextPcSel;
  ctrlStrobes_t       strobes;

  cpu_op_decode u_opdec (.opcode(opcode), .info(info));

  cpu_pc_select u_pcsel (.info(info), .aluZero(aluZero), .aluSign(aluSign), .pcSrc(nextPcSel));

  cpu_phase_gate u_gate (.phase(phase), .info(info), .pcSrc(nextPcSel), .strobes(strobes));

  assign pcWriteEn   = strobes.pcWriteEn;
  assign aluSrcShamt = strobes.aluSrcShamt;
  assign aluSrcImm   = strobes.aluSrcImm;
  assign wbFromMem   = strobes.wbFromMem;
  assign regWrite    = strobes.regWrite;
  assign wrDataAlu   = strobes.wrDataAlu;
  assign imemRead    = strobes.imemRead;
  assign dmemRead    = strobes.dmemRead;
  assign dmemWrite   = strobes.dmemWrite;
  assign irWrite     = strobes.irWrite;
  assign extSign     = strobes.extSign;
  assign pcSrc       = strobes.pcSrc;
  assign regDst      = strobes.regDst;
  assign aluOp       = strobes.aluOp;
endmodule

// File: rtl/cpu_ctrl_checker.sv
module cpu_ctrl_checker
  import cpu_ctrl_pkg::*;
(
  input logic [PHASE_W-1:0]  phase,
  input logic [OPC_W-1:0]    opcode,
  input logic                aluZero,
  input logic                aluSign,
  input logic                pcWriteEn,
  input logic                aluSrcShamt,
  input logic                aluSrcImm,
  input logic                wbFromMem,
  input logic                regWrite,
  input logic                wrDataAlu,
  input logic                imemRead,
  input logic                dmemRead,
  input logic                dmemWrite,
  input logic                irWrite,
  input logic                extSign,
  input logic [PCSRC_W-1:0]  pcSrc,
  input logic [REGDST_W-1:0] regDst,
  input logic [ALUOP_W-1:0]  aluOp
);
  logic known;
  assign known = !$isunknown({phase, opcode, aluZero, aluSign});

  always_comb begin
    if (known) begin
      AST_IR_FETCH_ONLY: assert (!irWrite || phase == PH_FETCH); // R1
      AST_IMEM_READ: assert (imemRead); // R1
      AST_SHAMT_EXECUTE: assert (!aluSrcShamt || (opcode == OPC_SHL &&
        (phase == PH_EXE_ARI || phase == PH_EXE_BRN || phase == PH_EXE_MEM))); // R2
      AST_STORE_SIGNED_IMM: assert (!dmemWrite || (aluSrcImm && extSign)); // R4
      AST_SLT_SIGNED_OP: assert (!(regWrite && opcode == OPC_SLT) || aluOp == ALU_LTS); // R5
      AST_LINK_WRITE: assert (!(regWrite && phase == PH_DECODE) || (regDst == RDST_LINK && !wrDataAlu)); // R6
      AST_BEQ_TAKEN: assert (!(opcode == OPC_BEQ && aluZero) || pcSrc == PCS_REL); // R7
      AST_BLTZ_TAKEN: assert (!(opcode == OPC_BLTZ && aluSign) || pcSrc == PCS_REL); // R7
      AST_REGWR_PHASE: assert (!regWrite ||
        phase == PH_WB_ARI || phase == PH_WB_LOAD || phase == PH_DECODE); // R8
      AST_MEM_EXCLUSIVE: assert (!(dmemRead && dmemWrite)); // R9
      AST_MEM_PHASE: assert (!(dmemRead || dmemWrite) || phase == PH_MEMACC); // R9
      AST_LOAD_FROM_MEM: assert (!dmemRead || wbFromMem); // R9
      AST_HALT_HOLDS_PC: assert (!(opcode == OPC_HALT) || !pcWriteEn); // R10
    end
  end
endmodule

bind cpu_ctrl_decoder cpu_ctrl_checker u_chk (
  .phase(phase), .opcode(opcode), .aluZero(aluZero), .aluSign(aluSign),
  .pcWriteEn(pcWriteEn), .aluSrcShamt(aluSrcShamt), .aluSrcImm(aluSrcImm),
  .wbFromMem(wbFromMem), .regWrite(regWrite), .wrDataAlu(wrDataAlu),
  .imemRead(imemRead), .dmemRead(dmemRead), .dmemWrite(dmemWrite),
  .irWrite(irWrite), .extSign(extSign), .pcSrc(pcSrc), .regDst(regDst), .aluOp(aluOp)
);

// File: tb/cpu_ctrl_decoder_tb.sv
`timescale 1ns/1ps
module cpu_ctrl_decoder_tb;
  logic       clk = 1'b0;
  logic [2:0] phase = 3'b000;
  logic [5:0] opcode = 6'b000000;
  logic       aluZero = 1'b0;
  logic       aluSign = 1'b0;
  logic       pcWriteEn, aluSrcShamt, aluSrcImm, wbFromMem, regWrite, wrDataAlu;
  logic       imemRead, dmemRead, dmemWrite, irWrite, extSign;
  logic [1:0] pcSrc, regDst;
  logic [2:0] aluOp;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cpu_ctrl_decoder u_dut (
    .phase(phase), .opcode(opcode), .aluZero(aluZero), .aluSign(aluSign),
    .pcWriteEn(pcWriteEn), .aluSrcShamt(aluSrcShamt), .aluSrcImm(aluSrcImm),
    .wbFromMem(wbFromMem), .regWrite(regWrite), .wrDataAlu(wrDataAlu),
    .imemRead(imemRead), .dmemRead(dmemRead), .dmemWrite(dmemWrite),
    .irWrite(irWrite), .extSign(extSign), .pcSrc(pcSrc), .regDst(regDst), .aluOp(aluOp)
  );

  // expected values, built from the requirement text
  logic eIr, eImem, eShamt, eImm, eSext, eWrAlu, eRegWr, eMemSrc, eMemRd, eMemWr, ePcWr;
  logic [2:0] eAlu;
  logic [1:0] eDst, ePc;

  task automatic expectFor(input logic [2:0] ph, input logic [5:0] op, input logic z, input logic s);
    bit aluWr, isJump;
    eIr    = (ph == 3'b000);                                                     // R1
    eImem  = 1'b1;                                                               // R1
    eShamt = (op == 6'b011000) && (ph == 3'b110 || ph == 3'b101 || ph == 3'b010); // R2
    eImm   = op inside {6'b000010, 6'b010001, 6'b010010, 6'b010011,
                        6'b100110, 6'b110001, 6'b110000};                        // R3
    eSext  = op inside {6'b000010, 6'b100110, 6'b110001, 6'b110000,
                        6'b110100, 6'b110101, 6'b110110};                        // R4
    case (op)                                                                    // R5
      6'b000001, 6'b110100, 6'b110101, 6'b110110: eAlu = 3'b001;
      6'b011000:                                  eAlu = 3'b010;
      6'b010000, 6'b010001:                       eAlu = 3'b100;
      6'b010010:                                  eAlu = 3'b011;
      6'b010011:                                  eAlu = 3'b111;
      6'b100110, 6'b100111:                       eAlu = 3'b110;
      default:                                    eAlu = 3'b000;
    endcase
    if (op inside {6'b000000, 6'b000001, 6'b010000, 6'b011000, 6'b100111})       // R6
      eDst = 2'b10;
    else if (op inside {6'b000010, 6'b010001, 6'b010010, 6'b010011, 6'b100110, 6'b110001})
      eDst = 2'b01;
    else
      eDst = 2'b00;
    if (op == 6'b111000 || op == 6'b111010) ePc = 2'b11;                          // R7
    else if (op == 6'b111001)               ePc = 2'b10;
    else if ((op == 6'b110100 && z) || (op == 6'b110101 && !z) || (op == 6'b110110 && s)) ePc = 2'b01;
    else                                    ePc = 2'b00;
    aluWr  = (eDst != 2'b00) && (op != 6'b110001);
    eRegWr = (ph == 3'b111 && aluWr) || (ph == 3'b100 && op == 6'b110001) ||
             (ph == 3'b001 && op == 6'b111010);                                  // R8
    eWrAlu = (op != 6'b111010);
    eMemSrc = (op == 6'b110001);                                                 // R9
    eMemRd  = (op == 6'b110001) && (ph == 3'b011);
    eMemWr  = (op == 6'b110000) && (ph == 3'b011);
    isJump = op inside {6'b111000, 6'b111001, 6'b111010};                        // R10, R11
    if (isJump)                                     ePcWr = (ph == 3'b001);
    else if (op inside {6'b110100, 6'b110101, 6'b110110}) ePcWr = (ph == 3'b101);
    else if (op == 6'b110000)                       ePcWr = (ph == 3'b011);
    else if (op == 6'b110001)                       ePcWr = (ph == 3'b100);
    else if (op == 6'b111111)                       ePcWr = 1'b0;
    else                                            ePcWr = (ph == 3'b111);
  endtask

  task automatic chk(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s phase=%b op=%b z=%b s=%b actual=%0d expected=%0d",
               req, name, phase, opcode, aluZero, aluSign, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] ph, input logic [5:0] op, input logic z, input logic s);
    @(negedge clk);
    phase = ph; opcode = op; aluZero = z; aluSign = s;
    #1;
  endtask

  task automatic compareAll();
    expectFor(phase, opcode, aluZero, aluSign);
    chk("R1", "irWrite", int'(irWrite), int'(eIr));
    chk("R1", "imemRead", int'(imemRead), int'(eImem));
    chk("R2", "aluSrcShamt", int'(aluSrcShamt), int'(eShamt));
    chk("R3", "aluSrcImm", int'(aluSrcImm), int'(eImm));
    chk("R4", "extSign", int'(extSign), int'(eSext));
    chk("R5", "aluOp", int'(aluOp), int'(eAlu));
    chk("R6", "regDst", int'(regDst), int'(eDst));
    chk("R7", "pcSrc", int'(pcSrc), int'(ePc));
    chk("R8", "regWrite", int'(regWrite), int'(eRegWr));
    chk("R8", "wrDataAlu", int'(wrDataAlu), int'(eWrAlu));
    chk("R9", "wbFromMem", int'(wbFromMem), int'(eMemSrc));
    chk("R9", "dmemRead", int'(dmemRead), int'(eMemRd));
    chk("R9", "dmemWrite", int'(dmemWrite), int'(eMemWr));
    chk("R10", "pcWriteEn", int'(pcWriteEn), int'(ePcWr));
  endtask

  // scenario: fetch step outputs for an add
  task automatic testFetch();
    apply(3'b000, 6'b000000, 1'b0, 1'b0);
    chk("R1", "fetch irWrite", int'(irWrite), 1);
    chk("R8", "fetch regWrite", int'(regWrite), 0);
    chk("R10", "fetch pcWriteEn", int'(pcWriteEn), 0);
  endtask

  // scenario: branch source follows flags in branch execute step
  task automatic testBranches();
    apply(3'b101, 6'b110100, 1'b1, 1'b0); chk("R7", "beq taken", int'(pcSrc), 1);
    apply(3'b101, 6'b110100, 1'b0, 1'b1); chk("R7", "beq not taken", int'(pcSrc), 0);
    apply(3'b101, 6'b110101, 1'b0, 1'b0); chk("R7", "bne taken", int'(pcSrc), 1);
    apply(3'b101, 6'b110110, 1'b1, 1'b0); chk("R7", "bltz not taken", int'(pcSrc), 0);
    apply(3'b101, 6'b110110, 1'b0, 1'b1); chk("R7", "bltz taken", int'(pcSrc), 1);
    chk("R10", "branch completes", int'(pcWriteEn), 1);
    chk("R5", "branch subtract", int'(aluOp), 1);
  endtask

  // scenario: link jump writes return address in decode step
  task automatic testLink();
    apply(3'b001, 6'b111010, 1'b0, 1'b0);
    chk("R8", "jal regWrite", int'(regWrite), 1);
    chk("R8", "jal wrDataAlu", int'(wrDataAlu), 0);
    chk("R6", "jal regDst", int'(regDst), 0);
    chk("R7", "jal pcSrc", int'(pcSrc), 3);
    chk("R10", "jal pcWriteEn", int'(pcWriteEn), 1);
  endtask

  // scenario: halt never moves the PC in any step
  task automatic testHalt();
    for (int p = 0; p < 8; p++) begin
      apply(3'(p), 6'b111111, 1'b1, 1'b1);
      chk("R10", "halt pcWriteEn", int'(pcWriteEn), 0);
    end
  endtask

  // scenario: unknown opcode behaves as no-write ALU op
  task automatic testUnknown();
    for (int p = 0; p < 8; p++) begin
      apply(3'(p), 6'b101010, 1'b0, 1'b0);
      chk("R11", "unknown regWrite", int'(regWrite), 0);
      chk("R11", "unknown dmemWrite", int'(dmemWrite), 0);
      chk("R11", "unknown aluOp", int'(aluOp), 0);
      chk("R11", "unknown aluSrcImm", int'(aluSrcImm), 0);
      chk("R11", "unknown regDst", int'(regDst), 0);
      chk("R11", "unknown pcWriteEn", int'(pcWriteEn), (p == 7) ? 1 : 0);
    end
  endtask

  // scenario: every step, opcode and flag combination
  task automatic testSweep();
    for (int p = 0; p < 8; p++)
      for (int o = 0; o < 64; o++)
        for (int f = 0; f < 4; f++) begin
          apply(3'(p), 6'(o), f[0], f[1]);
          compareAll();
        end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testFetch();
    testBranches();
    testLink();
    testHalt();
    testUnknown();
    testSweep();
    finish();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish();
  end
endmodule